// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Function Decoder

This block is the execute-stage arithmetic unit of a simple load/store processor core. It has two parts. The decoder turns a 2-bit operation class from the main control and the 6-bit function field of a register-type instruction into two control values: an invert bit for operand b and a 2-bit result select. The ALU then applies those values to two 32-bit operands and produces a result word and a zero flag. The whole path is combinational.

Subtraction does not have its own unit. It shares the adder: operand b is inverted and the carry-in is forced high. Set-less-than reads the sign of that same difference, corrected for signed overflow, and returns it in bit 0. The zero flag tells the branch logic whether two registers are equal, using the result of a subtraction. Both decoder outputs are also brought out as ports, so the control word can be seen directly.

Top module: `alu_unit`

## Requirements
- R1: With `alu_op_i` = 00 (memory address class), `b_invert_o` = 0, `op_sel_o` = 10, and `result_o` = a + b modulo 2^32, for any function field.
- R2: With `alu_op_i` = 01 (compare-for-branch class), `b_invert_o` = 1, `op_sel_o` = 10, and `result_o` = a − b modulo 2^32, for any function field.
- R3: With `alu_op_i` = 10 (function-field class), function 100000 gives add (invert 0, select 10) and function 100010 gives subtract (invert 1, select 10).
- R4: With `alu_op_i` = 10, function 100100 gives bitwise AND (invert 0, select 00) and function 100101 gives bitwise OR (invert 0, select 01).
- R5: With `alu_op_i` = 10, function 101010 gives set-less-than (invert 1, select 11). Bit 0 of the result is 1 exactly when a < b as signed two's-complement values, including when a − b overflows. Bits 31..1 are 0.
- R6: With `alu_op_i` = 10, any other function code, and `alu_op_i` = 11 with any function code, decode to add (invert 0, select 10).
- R7: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0, whatever operation is selected.
- R8: Add and subtract wrap at 32 bits. Examples: FFFFFFFF + 1 = 0, and 0 − 1 = FFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op_i | input | 2 | Operation class from main control |
| funct_i | input | 6 | Function field of the instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| b_invert_o | output | 1 | Decoded invert-b / carry-in bit |
| op_sel_o | output | 2 | Decoded result select |

## Verification
The bench sweeps every combination of operation class and function code against a set of edge operands: 0, 1, all ones, the most negative value, the most positive value, and mixed patterns. The weakest corner is set-less-than across the sign boundary, such as a most-negative value compared with a positive one. A design that used the raw difference sign there, without the overflow correction, would give the wrong answer in exactly those cases. A decoder that let an unknown function code or class 11 fall through to something other than add would give AND/OR or a difference instead of a sum. A carry-in left at 0 under invert would produce results off by one on every subtraction. The zero flag is also checked after a subtract of equal operands and on AND results that are all zeros.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } alu_sel_e;

  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_BR  = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_fn_dec.sv
module alu_fn_dec
  import alu_pkg::*;
(
  input  logic [1:0] alu_op_i,
  input  logic [5:0] funct_i,
  output logic       b_inv_o,
  output alu_sel_e   sel_o
);
  always_comb begin
    b_inv_o = 1'b0;
    sel_o   = SEL_SUM;
    case (alu_op_i)
      CLS_MEM: ;
      CLS_BR:  b_inv_o = 1'b1;
      CLS_FN: begin
        case (funct_i)
          FN_SUB: b_inv_o = 1'b1;
          FN_AND: sel_o = SEL_AND;
          FN_OR:  sel_o = SEL_OR;
          FN_SLT: begin
            b_inv_o = 1'b1;
            sel_o   = SEL_SLT;
          end
          default: ;  // FN_ADD and unknown codes: add
        endcase
      end
      default: ;  // class 11: add
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] bx_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             less_o
);
  logic ovf;

  assign sum_o  = a_i + bx_i + {{(WIDTH-1){1'b0}}, cin_i};
  // signed overflow: equal operand signs, differing sum sign
  assign ovf    = (a_i[WIDTH-1] == bx_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
  assign less_o = sum_o[WIDTH-1] ^ ovf;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_inv_i,
  input  alu_sel_e         sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] and_v, or_v, bx, sum;
  logic             less;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign and_v[i] = a_i[i] & b_i[i];
    assign or_v[i]  = a_i[i] | b_i[i];
    assign bx[i]    = b_i[i] ^ b_inv_i;
  end

  alu_addsub #(.WIDTH(WIDTH)) addsub_i (
    .a_i   (a_i),
    .bx_i  (bx),
    .cin_i (b_inv_i),
    .sum_o (sum),
    .less_o(less)
  );

  always_comb begin
    case (sel_i)
      SEL_AND: result_o = and_v;
      SEL_OR:  result_o = or_v;
      SEL_SUM: result_o = sum;
      default: result_o = {{(WIDTH-1){1'b0}}, less};
    endcase
  end

  assign zero_o = ~|result_o;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       alu_op_i,
  input  logic [5:0]       funct_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             b_invert_o,
  output logic [1:0]       op_sel_o
);
  alu_sel_e sel;
  logic     b_inv;

  alu_fn_dec dec_i (
    .alu_op_i(alu_op_i),
    .funct_i (funct_i),
    .b_inv_o (b_inv),
    .sel_o   (sel)
  );

  alu_core #(.WIDTH(WIDTH)) core_i (
    .a_i     (a_i),
    .b_i     (b_i),
    .b_inv_i (b_inv),
    .sel_i   (sel),
    .result_o(result_o),
    .zero_o  (zero_o)
  );

  assign b_invert_o = b_inv;
  assign op_sel_o   = sel;
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       alu_op_i,
  input logic [5:0]       funct_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             b_invert_o,
  input logic [1:0]       op_sel_o
);
  always_comb begin
    // R1
    add_class_chk: assert (alu_op_i != 2'b00 || result_o == a_i + b_i)
      else $error("add_class_chk");
    // R2
    sub_class_chk: assert (alu_op_i != 2'b01 || result_o == a_i - b_i)
      else $error("sub_class_chk");
    // R4
    and_decode_chk: assert (!(alu_op_i == 2'b10 && funct_i == 6'b100100) ||
                            (op_sel_o == 2'b00 && !b_invert_o))
      else $error("and_decode_chk");
    // R5
    slt_form_chk: assert (op_sel_o != 2'b11 || (result_o[WIDTH-1:1] == '0 && b_invert_o))
      else $error("slt_form_chk");
    // R6
    class3_chk: assert (alu_op_i != 2'b11 || (op_sel_o == 2'b10 && !b_invert_o))
      else $error("class3_chk");
    // R7
    zero_flag_chk: assert (zero_o == (result_o == '0))
      else $error("zero_flag_chk");
  end
endmodule

bind alu_unit alu_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .alu_op_i  (alu_op_i),
  .funct_i   (funct_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .result_o  (result_o),
  .zero_o    (zero_o),
  .b_invert_o(b_invert_o),
  .op_sel_o  (op_sel_o)
);

// File: tb/alu_unit_tb_top.sv
module alu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  alu_op;
  logic [5:0]  funct;
  logic [31:0] a, b, result;
  logic        zero, b_inv;
  logic [1:0]  op_sel;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu_unit dut_i (
    .alu_op_i  (alu_op),
    .funct_i   (funct),
    .a_i       (a),
    .b_i       (b),
    .result_o  (result),
    .zero_o    (zero),
    .b_invert_o(b_inv),
    .op_sel_o  (op_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s op=%b fn=%b a=%h b=%h act=%h exp=%h", req, alu_op, funct, a, b, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'hF0F0_0F0F;
      default: return 32'h8000_0001;
    endcase
  endfunction

  // kind: 0 add 1 sub 2 and 3 or 4 slt
  task automatic expect_model(output int kind, output string req);
    kind = 0;
    req = "R6";
    case (alu_op)
      2'b00: req = "R1";
      2'b01: begin kind = 1; req = "R2"; end
      2'b10: case (funct)
        6'b100000: req = "R3";
        6'b100010: begin kind = 1; req = "R3"; end
        6'b100100: begin kind = 2; req = "R4"; end
        6'b100101: begin kind = 3; req = "R4"; end
        6'b101010: begin kind = 4; req = "R5"; end
        default: req = "R6";
      endcase
      default: req = "R6";
    endcase
  endtask

  initial begin
    alu_op = 2'b00; funct = 6'd0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #5;
    // R7 at idle inputs: 0 + 0
    chk(result == 32'd0 && zero, "R7", {31'd0, zero}, 32'd1);
    // R8 wrap
    @(posedge clk); a = 32'hFFFF_FFFF; b = 32'd1; alu_op = 2'b00; #5;
    chk(result == 32'd0 && zero, "R8", result, 32'd0);
    @(posedge clk); a = 32'd0; b = 32'd1; alu_op = 2'b01; #5;
    chk(result == 32'hFFFF_FFFF && !zero, "R8", result, 32'hFFFF_FFFF);

    for (int op = 0; op < 4; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        for (int ia = 0; ia < 8; ia++) begin
          for (int ib = 0; ib < 8; ib++) begin
            int kind;
            string req;
            logic [31:0] exp_r;
            logic        exp_inv;
            logic [1:0]  exp_sel;
            @(posedge clk);
            alu_op = op[1:0]; funct = fn[5:0]; a = pat(ia); b = pat(ib);
            #5;
            expect_model(kind, req);
            case (kind)
              0: begin exp_r = a + b; exp_inv = 0; exp_sel = 2'b10; end
              1: begin exp_r = a - b; exp_inv = 1; exp_sel = 2'b10; end
              2: begin exp_r = a & b; exp_inv = 0; exp_sel = 2'b00; end
              3: begin exp_r = a | b; exp_inv = 0; exp_sel = 2'b01; end
              default: begin
                exp_r = {31'd0, ($signed(a) < $signed(b))};
                exp_inv = 1; exp_sel = 2'b11;
              end
            endcase
            chk(result === exp_r, req, result, exp_r);
            chk(b_inv === exp_inv && op_sel === exp_sel, req, {29'd0, b_inv, op_sel}, {29'd0, exp_inv, exp_sel});
            chk(zero === (exp_r == 32'd0), "R7", {31'd0, zero}, {31'd0, exp_r == 32'd0});
          end
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule